// File: doc/BRIEF.md
# Translation Table Range Loader

This sequencer programs a contiguous run of entries in an on-chip address-translation table. The caller supplies a first entry index, an entry count and a 64-bit base DMA address. The block writes one entry for each 4 KiB page, working upward. It then sends a single commit command. Next it polls the highest entry it wrote until that entry reads back correctly. Finally it reads the other entries back from the top down and compares each one.

A run that cannot complete must not leave entries behind. If the poll runs out of attempts, or a verify read returns the wrong value, the block sends a clear command for the range it wrote. Completion is one `done_o` pulse that carries a two-bit outcome code. The polling interval comes from the clock frequency parameter, so a bench can shorten it to a few cycles.

Top module: `bt_loader`

## Requirements
- R1: A request is rejected with status 1 (range) when the count is zero or when start index plus count is greater than or equal to `TBL_SIZE`. A rejected request makes no table write, no table read and no command.
- R2: Each written entry holds the page number (address bits 63:12). Entry bits 31:0 carry the low 32 bits of the page and bits 51:32 carry the upper 20 bits. Bits 63:52 (region and owner) are written as zero.
- R3: Entries are written exactly once each, at indices start, start+1, … start+count-1. Each successive entry holds a page number one greater than the entry before it, which is 4 KiB more address.
- R4: After the last write and before any read, exactly one command is issued, with update=1 and clear=0.
- R5: Only the last index is polled. The first poll read comes `WAIT_CYC`+1 cycles after the commit command, and each further poll read comes `WAIT_CYC`+2 cycles after the previous one. A poll stops at the first read whose two address fields match. At most `POLL_MAX` poll reads are made.
- R6: If none of the `POLL_MAX` poll reads matches, the status is 2 (timeout). The block then issues one command with update=0, clear=1 and inclusive bounds start..start+count-1.
- R7: After a matching poll, the entries from start+count-2 down to start are each read once, in descending order. If all of them match, the status is 0 and no clear command is issued.
- R8: At the first verify mismatch the status is 3 (fault). No further reads are made, and one clear command covering start..start+count-1 is issued.
- R9: `done_o` is high for exactly one cycle at the end of every request, with `status_o` valid in that cycle. Out of reset, `busy_o`, `done_o`, `tbl_we_o`, `tbl_re_o` and `cmd_valid_o` are low.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. The running request completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| start_idx_i | input | IDX_W | First entry index |
| count_i | input | IDX_W+1 | Number of entries |
| base_addr_i | input | 64 | DMA address of the first page |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 range, 2 timeout, 3 fault |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_re_o | output | 1 | Table read strobe; data is expected in the following cycle |
| tbl_idx_o | output | IDX_W | Table entry index |
| tbl_wdata_o | output | 64 | Entry write data |
| tbl_rdata_i | input | 64 | Entry read data |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_upd_o | output | 1 | Commit bit |
| cmd_clr_o | output | 1 | Clear bit |
| cmd_clr_start_o | output | IDX_W | Clear range, first index |
| cmd_clr_end_o | output | IDX_W | Clear range, last index (inclusive) |

## Verification
The poll's match test and its attempt limit are decided in the same check cycle. When the final permitted poll read is also the first one to match, only one of the two outcomes may win. The bench's table model returns stale data for a programmable number of reads. With `POLL_MAX`-1 stale reads, the final poll matches and must give status 0 with no clear. With `POLL_MAX` stale reads, the same setup must give a timeout and a clear. In both cases the count and spacing of the poll reads are compared against the limit.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int ADDR_W     = 64;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int LO_W       = 32;
  localparam int HI_W       = PAGE_W - LO_W;
  localparam int ENTRY_W    = 64;

  typedef struct packed {
    logic [9:0]      owner;
    logic [1:0]      region;
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
  } bt_entry_t;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_RANGE   = 2'd1,
    ST_TIMEOUT = 2'd2,
    ST_FAULT   = 2'd3
  } bt_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WRITE, S_COMMIT, S_WAIT, S_POLL_RD, S_POLL_CHK,
    S_VER_RD, S_VER_CHK, S_CLEAR, S_DONE
  } bt_state_e;
endpackage

// File: rtl/bt_entry_codec.sv
module bt_entry_codec
  import bt_pkg::*;
(
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [ENTRY_W-1:0] rdata_i,
  output logic [ENTRY_W-1:0] wdata_o,
  output logic               match_o
);
  bt_entry_t wr_e, rd_e;
  logic      unused_rd_tag;

  always_comb begin
    wr_e        = '0;
    wr_e.lo     = page_i[LO_W-1:0];
    wr_e.hi     = page_i[PAGE_W-1:LO_W];
    wdata_o     = wr_e;
    rd_e        = bt_entry_t'(rdata_i);
    // only the two address fields take part in the comparison
    match_o     = (rd_e.lo == wr_e.lo) && (rd_e.hi == wr_e.hi);
  end

  assign unused_rd_tag = ^{rd_e.owner, rd_e.region};
endmodule

// File: rtl/bt_interval_timer.sv
module bt_interval_timer #(
  parameter int WAIT_CYC = 1000,
  localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  assign expired_o = en_i && (cnt_q == CW'(WAIT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (!expired_o)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bt_loader.sv
module bt_loader
  import bt_pkg::*;
#(
  parameter int TBL_SIZE = 1024,
  parameter int CLK_HZ   = 250_000_000,
  parameter int POLL_MAX = 100,
  localparam int IDX_W    = $clog2(TBL_SIZE),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [63:0]        base_addr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         status_o,
  output logic               tbl_we_o,
  output logic               tbl_re_o,
  output logic [IDX_W-1:0]   tbl_idx_o,
  output logic [63:0]        tbl_wdata_o,
  input  logic [63:0]        tbl_rdata_i,
  output logic               cmd_valid_o,
  output logic               cmd_upd_o,
  output logic               cmd_clr_o,
  output logic [IDX_W-1:0]   cmd_clr_start_o,
  output logic [IDX_W-1:0]   cmd_clr_end_o
);
  localparam int WAIT_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int PW       = $clog2(POLL_MAX + 1);
  localparam int SUM_W    = IDX_W + 2;
  localparam logic [SUM_W-1:0] TBL_LIM = SUM_W'(TBL_SIZE);

  bt_state_e          state_q;
  logic [IDX_W-1:0]   idx_q, first_q, last_q;
  logic [PAGE_W-1:0]  page_q;
  logic [PW-1:0]      poll_q;
  bt_status_e         status_q;

  logic [SUM_W-1:0]   req_end;
  logic               req_bad;
  logic               match;
  logic               tmr_expired;
  logic               unused_base_lsb;

  assign req_end = SUM_W'(start_idx_i) + SUM_W'(count_i);
  assign req_bad = (count_i == '0) || (req_end >= TBL_LIM);
  assign unused_base_lsb = ^base_addr_i[PAGE_SHIFT-1:0];

  bt_entry_codec u_codec (
    .page_i  (page_q),
    .rdata_i (tbl_rdata_i),
    .wdata_o (tbl_wdata_o),
    .match_o (match)
  );

  bt_interval_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state_q == S_WAIT),
    .expired_o (tmr_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      first_q  <= '0;
      last_q   <= '0;
      page_q   <= '0;
      poll_q   <= '0;
      status_q <= ST_OK;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (req_bad) begin
            status_q <= ST_RANGE;
            state_q  <= S_DONE;
          end else begin
            idx_q   <= start_idx_i;
            first_q <= start_idx_i;
            last_q  <= IDX_W'(req_end - 1'b1);
            page_q  <= base_addr_i[63:PAGE_SHIFT];
            state_q <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (idx_q == last_q) state_q <= S_COMMIT;
          else begin
            idx_q  <= idx_q + 1'b1;
            page_q <= page_q + 1'b1;
          end
        end
        S_COMMIT: begin
          poll_q  <= '0;
          state_q <= S_WAIT;
        end
        S_WAIT:    if (tmr_expired) state_q <= S_POLL_RD;
        S_POLL_RD: state_q <= S_POLL_CHK;
        S_POLL_CHK: begin
          if (match) begin
            if (idx_q == first_q) begin
              status_q <= ST_OK;
              state_q  <= S_DONE;
            end else begin
              idx_q   <= idx_q - 1'b1;
              page_q  <= page_q - 1'b1;
              state_q <= S_VER_RD;
            end
          end else if (poll_q == PW'(POLL_MAX - 1)) begin
            status_q <= ST_TIMEOUT;
            state_q  <= S_CLEAR;
          end else begin
            poll_q  <= poll_q + 1'b1;
            state_q <= S_WAIT;
          end
        end
        S_VER_RD: state_q <= S_VER_CHK;
        S_VER_CHK: begin
          if (!match) begin
            status_q <= ST_FAULT;
            state_q  <= S_CLEAR;
          end else if (idx_q == first_q) begin
            status_q <= ST_OK;
            state_q  <= S_DONE;
          end else begin
            idx_q   <= idx_q - 1'b1;
            page_q  <= page_q - 1'b1;
            state_q <= S_VER_RD;
          end
        end
        S_CLEAR: state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o          = (state_q != S_IDLE);
  assign done_o          = (state_q == S_DONE);
  assign status_o        = status_q;
  assign tbl_we_o        = (state_q == S_WRITE);
  assign tbl_re_o        = (state_q == S_POLL_RD) || (state_q == S_VER_RD);
  assign tbl_idx_o       = idx_q;
  assign cmd_valid_o     = (state_q == S_COMMIT) || (state_q == S_CLEAR);
  assign cmd_upd_o       = (state_q == S_COMMIT);
  assign cmd_clr_o       = (state_q == S_CLEAR);
  assign cmd_clr_start_o = first_q;
  assign cmd_clr_end_o   = last_q;
endmodule

// File: rtl/bt_loader_chk.sv
module bt_loader_chk #(
  parameter int TBL_SIZE = 1024,
  parameter int IDX_W    = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [IDX_W-1:0] start_idx_i,
  input logic [IDX_W:0]   count_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       status_o,
  input logic             tbl_we_o,
  input logic             tbl_re_o,
  input logic [IDX_W-1:0] tbl_idx_o,
  input logic [63:0]      tbl_wdata_o,
  input logic             cmd_valid_o,
  input logic             cmd_upd_o,
  input logic             cmd_clr_o,
  input logic [IDX_W-1:0] cmd_clr_start_o,
  input logic [IDX_W-1:0] cmd_clr_end_o
);
  logic [IDX_W+1:0] end_sum;
  assign end_sum = (IDX_W+2)'(start_idx_i) + (IDX_W+2)'(count_i);

  AST_RANGE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (count_i == '0 || end_sum >= (IDX_W+2)'(TBL_SIZE)))
    |=> (done_o && status_o == 2'd1 && !tbl_we_o)); // R1
  AST_ZERO_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_o |-> tbl_wdata_o[63:52] == '0); // R2
  AST_IDX_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_o && $past(tbl_we_o)) |-> tbl_idx_o == $past(tbl_idx_o) + 1'b1); // R3
  AST_PAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_o && $past(tbl_we_o)) |-> tbl_wdata_o[51:0] == $past(tbl_wdata_o[51:0]) + 1'b1); // R3
  AST_COMMIT_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_upd_o) |-> $past(tbl_we_o)); // R4
  AST_CMD_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_upd_o != cmd_clr_o)); // R4
  AST_CLR_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_clr_o) |-> cmd_clr_start_o <= cmd_clr_end_o); // R6
  AST_CLR_FAIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_clr_o) |=> (done_o && status_o[1])); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tbl_we_o && !tbl_re_o && !cmd_valid_o && !done_o)); // R10
endmodule

bind bt_loader bt_loader_chk #(.TBL_SIZE(TBL_SIZE), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_idx_i(start_idx_i),
  .count_i(count_i), .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
  .tbl_we_o(tbl_we_o), .tbl_re_o(tbl_re_o), .tbl_idx_o(tbl_idx_o),
  .tbl_wdata_o(tbl_wdata_o), .cmd_valid_o(cmd_valid_o), .cmd_upd_o(cmd_upd_o),
  .cmd_clr_o(cmd_clr_o), .cmd_clr_start_o(cmd_clr_start_o),
  .cmd_clr_end_o(cmd_clr_end_o)
);

// File: tb/test_bt_loader.sv
module test_bt_loader;
  localparam int TS    = 64;
  localparam int IW    = 6;
  localparam int HZ    = 4000;
  localparam int WC    = HZ / 1000;
  localparam int PMAX  = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] s_idx = '0;
  logic [IW:0]   s_cnt = '0;
  logic [63:0]   base = '0;
  logic busy, done, we, re, cv, cu, cc;
  logic [1:0] st;
  logic [IW-1:0] tidx, cs, ce;
  logic [63:0] wdat, rdat = '0;

  always #2.5 clk = ~clk;

  bt_loader #(.TBL_SIZE(TS), .CLK_HZ(HZ), .POLL_MAX(PMAX)) i_bt_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_idx_i(s_idx),
    .count_i(s_cnt), .base_addr_i(base), .busy_o(busy), .done_o(done),
    .status_o(st), .tbl_we_o(we), .tbl_re_o(re), .tbl_idx_o(tidx),
    .tbl_wdata_o(wdat), .tbl_rdata_i(rdat), .cmd_valid_o(cv), .cmd_upd_o(cu),
    .cmd_clr_o(cc), .cmd_clr_start_o(cs), .cmd_clr_end_o(ce)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // table model and logs
  logic [63:0] staged [TS], visible [TS];
  bit commit_en = 1, corrupt_en = 0;
  int corrupt_at = 0, miss_left = 0;
  int wr_n, rd_n, cmd_n, done_n, wr_last_cyc;
  int wr_idx [TS]; logic [63:0] wr_dat [TS];
  int rd_idx [512]; int rd_cyc [512];
  bit cmd_u [8]; int cmd_s [8], cmd_e [8], cmd_c [8];
  int done_st;

  initial for (int i = 0; i < TS; i++) begin staged[i] = '0; visible[i] = '0; end

  always @(negedge clk) if (rst_n) begin
    if (we) begin
      staged[tidx] = wdat;
      if (wr_n < TS) begin wr_idx[wr_n] = int'(tidx); wr_dat[wr_n] = wdat; end
      wr_n++; wr_last_cyc = cyc;
    end
    if (re) begin
      if (miss_left > 0) begin rdat = '0; miss_left--; end
      else rdat = visible[tidx];
      if (rd_n < 512) begin rd_idx[rd_n] = int'(tidx); rd_cyc[rd_n] = cyc; end
      rd_n++;
    end
    if (cv) begin
      if (cmd_n < 8) begin
        cmd_u[cmd_n] = cu; cmd_s[cmd_n] = int'(cs); cmd_e[cmd_n] = int'(ce); cmd_c[cmd_n] = cyc;
      end
      cmd_n++;
      if (cu && commit_en) begin
        for (int i = 0; i < TS; i++) visible[i] = staged[i];
        if (corrupt_en) visible[corrupt_at] = visible[corrupt_at] ^ 64'h1;
      end
      if (cc) for (int i = int'(cs); i <= int'(ce); i++) begin visible[i] = '0; staged[i] = '0; end
    end
    if (done) begin done_n++; done_st = int'(st); end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    wr_n = 0; rd_n = 0; cmd_n = 0; done_n = 0; done_st = -1; wr_last_cyc = 0;
  endtask

  task automatic pulse(input int i, input int n, input logic [63:0] b);
    @(negedge clk);
    s_idx = IW'(i); s_cnt = (IW+1)'(n); base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 30000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_entry(input logic [63:0] b, input int k);
    logic [51:0] p = b[63:12] + 52'(k);
    return {12'h000, p};
  endfunction

  // writes, entry contents and the single commit for a run that reached commit
  task automatic check_writes(input int i, input int n, input logic [63:0] b, input string tag);
    chk(wr_n == n, {tag, " R3 write count"}, 64'(wr_n), 64'(n));
    for (int k = 0; k < n && k < wr_n; k++) begin
      chk(wr_idx[k] == i + k, {tag, " R3 write index"}, 64'(wr_idx[k]), 64'(i + k));
      chk(wr_dat[k] == exp_entry(b, k), {tag, " R2 entry data"}, wr_dat[k], exp_entry(b, k));
    end
    chk(cmd_n >= 1 && cmd_u[0] && cmd_c[0] == wr_last_cyc + 1, {tag, " R4 commit after writes"},
        64'(cmd_c[0]), 64'(wr_last_cyc + 1));
    chk(rd_n >= 1 && rd_cyc[0] == cmd_c[0] + WC + 1, {tag, " R5 first poll spacing"},
        64'(rd_cyc[0] - cmd_c[0]), 64'(WC + 1));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !we && !re && !cv, "R9 reset outputs quiet",
        {59'b0, busy, done, we, re, cv}, 64'h0);
  endtask

  task automatic t_ok(input int i, input int n, input logic [63:0] b, input string tag);
    clear_logs(); commit_en = 1; corrupt_en = 0; miss_left = 0;
    pulse(i, n, b); wait_done();
    check_writes(i, n, b, tag);
    chk(cmd_n == 1, {tag, " R7 no clear on success"}, 64'(cmd_n), 64'd1);
    chk(rd_n == n, {tag, " R7 read count"}, 64'(rd_n), 64'(n));
    for (int k = 0; k < n && k < rd_n; k++)
      chk(rd_idx[k] == i + n - 1 - k, {tag, " R7 descending read"}, 64'(rd_idx[k]), 64'(i + n - 1 - k));
    chk(done_n == 1 && done_st == 0, {tag, " R9 done once with ok"}, 64'(done_st), 64'd0);
  endtask

  task automatic t_range(input int i, input int n, input string tag);
    clear_logs();
    pulse(i, n, 64'h5000); wait_done();
    chk(done_n == 1 && done_st == 1, {tag, " R1 range status"}, 64'(done_st), 64'd1);
    chk(wr_n == 0 && rd_n == 0 && cmd_n == 0, {tag, " R1 no table traffic"},
        64'(wr_n + rd_n + cmd_n), 64'd0);
  endtask

  task automatic t_poll_edge();
    clear_logs(); commit_en = 1; corrupt_en = 0; miss_left = PMAX - 1;
    pulse(10, 3, 64'h0000_0042_0000_0000); wait_done();
    check_writes(10, 3, 64'h0000_0042_0000_0000, "edge");
    chk(rd_n == PMAX + 2, "R5 last poll matches, read count", 64'(rd_n), 64'(PMAX + 2));
    chk(rd_idx[PMAX - 1] == 12 && rd_cyc[1] - rd_cyc[0] == WC + 2, "R5 poll index and spacing",
        64'(rd_cyc[1] - rd_cyc[0]), 64'(WC + 2));
    chk(done_st == 0 && cmd_n == 1, "R5 match wins on final attempt", 64'(done_st), 64'd0);
  endtask

  task automatic t_timeout();
    clear_logs(); commit_en = 1; corrupt_en = 0; miss_left = PMAX;
    pulse(20, 5, 64'h0000_0000_0ABC_D000); wait_done();
    miss_left = 0;
    chk(rd_n == PMAX, "R5 poll limit", 64'(rd_n), 64'(PMAX));
    chk(done_n == 1 && done_st == 2, "R6 timeout status", 64'(done_st), 64'd2);
    chk(cmd_n == 2 && !cmd_u[1] && cmd_s[1] == 20 && cmd_e[1] == 24, "R6 clear range",
        {32'(cmd_s[1]), 32'(cmd_e[1])}, {32'd20, 32'd24});
  endtask

  task automatic t_fault();
    clear_logs(); commit_en = 1; corrupt_en = 1; corrupt_at = 31; miss_left = 0;
    pulse(30, 4, 64'h0000_0FFF_FFFF_E000); wait_done();
    corrupt_en = 0;
    check_writes(30, 4, 64'h0000_0FFF_FFFF_E000, "fault");
    chk(rd_n == 3 && rd_idx[2] == 31, "R8 reads stop at mismatch", 64'(rd_n), 64'd3);
    chk(done_st == 3, "R8 fault status", 64'(done_st), 64'd3);
    chk(cmd_n == 2 && cmd_s[1] == 30 && cmd_e[1] == 33, "R8 clear whole range",
        {32'(cmd_s[1]), 32'(cmd_e[1])}, {32'd30, 32'd33});
  endtask

  task automatic t_busy();
    clear_logs(); commit_en = 1; corrupt_en = 0; miss_left = 0;
    pulse(40, 6, 64'h1234_0000_0000_0000);
    repeat (2) @(negedge clk);
    pulse(0, 2, 64'hFFFF_0000_0000_0000);
    wait_done();
    check_writes(40, 6, 64'h1234_0000_0000_0000, "busy R10");
    chk(done_n == 1 && done_st == 0, "R10 second start ignored", 64'(done_n), 64'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_ok(5, 4, 64'hABCD_E123_4567_8000, "ok");
    t_ok(7, 1, 64'h0000_0000_0000_1000, "single");
    t_ok(60, 3, 64'h0000_0FFF_FFFF_E000, "top");
    t_range(60, 4, "end at size");
    t_range(3, 0, "zero count");
    t_range(63, 1, "last index");
    t_poll_edge();
    t_timeout();
    t_fault();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule